// File: doc/BRIEF.md
# Bus Master Burst Sequencer with Resume After Ownership Loss

This block is the address-side engine of a bus master on a pipelined, ready-paced system bus. A single request gives the start address, the burst kind, the transfer size and, for bursts of open length, a beat count. The block then drives transfer type, address, burst code and size for every beat. It steps forward only on cycles where the bus accepts an address. Arbitration, data buses and write data belong to other blocks.

When the bus grant is taken away partway through a burst, the sequencer stops issuing beats. When it owns the bus again, it finishes the remaining beats as an open-length incrementing burst. That burst starts at the first address that was never issued. If the interrupted burst was a wrapping one, the remaining addresses keep the wrap order. Each jump back to the bottom of the wrap region opens a new open-length burst, because an incrementing burst cannot wrap. The block also never lets an incrementing burst run across a 1 KB address boundary. A fixed-length incrementing request that would cross the boundary is recoded as open-length, and a fresh burst begins at the boundary.

Top module: `burst_seq_master`

## Requirements
- R1: After reset, busTrans is IDLE (2'b00), busy is 0 and done is 0.
- R2: Transfer codes are IDLE=2'b00, NONSEQ=2'b10 and SEQ=2'b11. The first beat of every burst is NONSEQ and each later beat of the same burst is SEQ.
- R3: Burst codes are SINGLE=000, INCR (open length)=001, WRAP4=010, INCR4=011, WRAP8=100, INCR8=101, WRAP16=110 and INCR16=111. Each incrementing beat is 2^size bytes above the one before it. A wrapping burst wraps at a boundary of beats×2^size bytes, so WRAP4 words from 0x34 give 0x34, 0x38, 0x3C, 0x30.
- R4: A beat is taken only on a rising edge where ready is 1. While ready is 0, busTrans, busAddr and busBurst hold their values.
- R5: SINGLE issues 1 beat, the fixed kinds issue 4, 8 or 16 beats, and INCR issues startBeats beats, where a count of 0 counts as 1.
- R6: The block owns the bus from the cycle after a rising edge with ready=1 and grant=1, and loses it after a rising edge with ready=1 and grant=0. It drives IDLE whenever it does not own the bus.
- R7: If ownership is lost after at least one beat has been issued, the remaining beats restart at the first address not yet issued. They are sent as NONSEQ followed by SEQ, with burst code INCR.
- R8: In a resumed wrapping burst, the beat that returns to the bottom of the wrap region is NONSEQ with code INCR.
- R9: A fixed incrementing request that would cross a 1 KB boundary is issued with code INCR, and the first beat at the boundary is NONSEQ. An open-length INCR burst also restarts with NONSEQ at every 1 KB boundary.
- R10: done pulses high for exactly one cycle, two cycles after the last beat's address is taken when ready stays high. busy falls in the same cycle.
- R11: startReq has no effect while busy is 1.
- R12: If ownership is lost before any beat is issued, the burst later starts with its original burst code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Request a new burst (taken when not busy) |
| startAddr | input | ADDR_W | First address, aligned to the size |
| startBurst | input | 3 | Requested burst code |
| startSize | input | 3 | Bytes per beat as log2 |
| startBeats | input | BEAT_W | Beat count for INCR requests |
| grant | input | 1 | Bus grant from the arbiter |
| ready | input | 1 | Bus ready |
| busTrans | output | 2 | Transfer type |
| busAddr | output | ADDR_W | Transfer address |
| busBurst | output | 3 | Burst code of the current beat |
| busSize | output | 3 | Transfer size |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse after the last beat completes |

## Verification
The bench builds the block with a 16-bit address, a 20-beat limit for open-length bursts and the 1 KB boundary (KB_LG of 10). This lets short address literals reach the 0x3FC/0x400 and 0x7FC/0x800 boundaries directly. The 20-beat limit keeps every fixed kind legal. Grant is dropped on the exact cycle a first beat is taken, for both an incrementing burst and a wrapping one, so the resume address and the forced NONSEQ beats can be observed. A grant withheld from before the start shows that the original code is kept when no beat was issued.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  localparam logic [2:0] BT_SINGLE = 3'b000;
  localparam logic [2:0] BT_INCR   = 3'b001;

  // control -> datapath strobes
  typedef struct packed {
    logic load;     // capture a new request
    logic advance;  // current address was taken by the bus
    logic demote;   // remaining beats become an open-length burst
  } seq_strobe_t;

  // number of beats a request stands for
  function automatic int unsigned beatsOf(input logic [2:0] kind, input int unsigned asked);
    if (kind[2:1] != 2'b00) return 32'd2 << kind[2:1];
    if (kind[0] && asked != 0) return asked;
    return 32'd1;
  endfunction

  function automatic logic isWrapKind(input logic [2:0] kind);
    return !kind[0] && (kind[2:1] != 2'b00);
  endfunction

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
#(
  parameter int MAX_BEATS = 32,
  parameter int BEAT_W    = $clog2(MAX_BEATS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [2:0]        startBurst,
  input  logic [BEAT_W-1:0] startBeats,
  input  logic              grant,
  input  logic              ready,
  input  logic              breakNext,
  output seq_strobe_t       strobe,
  output trans_e            busTrans,
  output logic              busy,
  output logic              done
);

  logic              busyQ, ownedQ, startedQ, nonseqQ, dataPendQ, doneQ;
  logic [BEAT_W-1:0] beatsLeftQ;
  logic [BEAT_W-1:0] reqCount;
  logic              loadNow, active, accept, lossNow, lastDone;

  always_comb begin
    reqCount = BEAT_W'(beatsOf(startBurst, 32'(startBeats)));
    loadNow  = startReq && !busyQ;
    active   = busyQ && ownedQ && (beatsLeftQ != '0);
    accept   = active && ready;
    lossNow  = ready && !grant && ownedQ && busyQ;
    lastDone = busyQ && ready && dataPendQ && (beatsLeftQ == '0);
  end

  always_comb begin
    strobe.load    = loadNow;
    strobe.advance = accept;
    strobe.demote  = lossNow && (startedQ || accept);
  end

  always_comb begin
    if (!active)      busTrans = TR_IDLE;
    else if (nonseqQ) busTrans = TR_NONSEQ;
    else              busTrans = TR_SEQ;
  end

  assign busy = busyQ;
  assign done = doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ      <= 1'b0;
      ownedQ     <= 1'b0;
      startedQ   <= 1'b0;
      nonseqQ    <= 1'b1;
      dataPendQ  <= 1'b0;
      doneQ      <= 1'b0;
      beatsLeftQ <= '0;
    end else begin
      if (ready) begin
        ownedQ    <= grant;
        dataPendQ <= accept;
      end
      doneQ <= lastDone;
      if (loadNow) begin
        busyQ      <= 1'b1;
        beatsLeftQ <= reqCount;
        startedQ   <= 1'b0;
        nonseqQ    <= 1'b1;
      end else begin
        if (lastDone) busyQ <= 1'b0;
        if (accept) begin
          beatsLeftQ <= beatsLeftQ - BEAT_W'(1);
          startedQ   <= 1'b1;
          nonseqQ    <= breakNext;
        end
        if (lossNow) nonseqQ <= 1'b1;
      end
    end
  end

  assert_idle_when_unowned_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !grant) |=> (busTrans == TR_IDLE));

  assert_seq_after_active_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busTrans == TR_SEQ) |-> ($past(busTrans) != TR_IDLE));

  assert_hold_on_wait_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busTrans != TR_IDLE && !ready) |=> ($stable(busTrans) && $stable(beatsLeftQ)));

  assert_done_one_cycle_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_clears_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

// File: rtl/burst_seq_path.sv
module burst_seq_path
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_BEATS = 32,
  parameter int BEAT_W    = $clog2(MAX_BEATS + 1),
  parameter int KB_LG     = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       strobe,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [2:0]        startBurst,
  input  logic [2:0]        startSize,
  input  logic [BEAT_W-1:0] startBeats,
  output logic [ADDR_W-1:0] addrOut,
  output logic [2:0]        burstOut,
  output logic [2:0]        sizeOut,
  output logic              breakNext
);

  localparam int SPAN_W = KB_LG + BEAT_W + 8;

  logic [ADDR_W-1:0] addrQ;
  logic [2:0]        burstQ, sizeQ, wrapLgQ;
  logic              wrapModeQ;

  logic [ADDR_W-1:0] stepBytes, wrapMask, linNext, nextAddr;
  logic              atWrap, atKb, crossKb, fixedIncr;
  logic [2:0]        loadBurst;

  always_comb begin
    stepBytes = ADDR_W'(1) << sizeQ;
    wrapMask  = (stepBytes << wrapLgQ) - ADDR_W'(1);
    linNext   = addrQ + stepBytes;
    nextAddr  = wrapModeQ ? ((addrQ & ~wrapMask) | (linNext & wrapMask)) : linNext;
    atWrap    = wrapModeQ && ((linNext & wrapMask) == '0);
  end

  generate
    if (ADDR_W > KB_LG) begin : g_kb
      logic [SPAN_W-1:0] loadCount, endOff;
      always_comb begin
        loadCount = SPAN_W'(beatsOf(startBurst, 32'(startBeats)));
        endOff    = SPAN_W'(startAddr[KB_LG-1:0]) + (loadCount << startSize);
        crossKb   = endOff > (SPAN_W'(1) << KB_LG);
        atKb      = (linNext[KB_LG-1:0] == '0);
      end
    end else begin : g_nokb
      always_comb begin
        crossKb = 1'b0;
        atKb    = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    fixedIncr = startBurst[0] && (startBurst != BT_INCR);
    loadBurst = (fixedIncr && crossKb) ? BT_INCR : startBurst;
    breakNext = (burstQ == BT_INCR) && (wrapModeQ ? atWrap : atKb);
  end

  assign addrOut  = addrQ;
  assign burstOut = burstQ;
  assign sizeOut  = sizeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ     <= '0;
      burstQ    <= BT_SINGLE;
      sizeQ     <= '0;
      wrapLgQ   <= 3'd2;
      wrapModeQ <= 1'b0;
    end else if (strobe.load) begin
      addrQ     <= startAddr;
      sizeQ     <= startSize;
      burstQ    <= loadBurst;
      wrapModeQ <= isWrapKind(startBurst);
      wrapLgQ   <= {1'b0, startBurst[2:1]} + 3'd1;
    end else begin
      if (strobe.advance) addrQ  <= nextAddr;
      if (strobe.demote)  burstQ <= BT_INCR;
    end
  end

  assert_wrap_stays_in_region_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && wrapModeQ) |=>
      ((addrQ & ~$past(wrapMask)) == ($past(addrQ) & ~$past(wrapMask))));

  assert_demote_gives_incr_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.demote && !strobe.load) |=> (burstQ == BT_INCR));

endmodule

// File: rtl/burst_seq_master.sv
module burst_seq_master
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_BEATS = 32,
  parameter int KB_LG     = 10,
  localparam int BEAT_W   = $clog2(MAX_BEATS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [2:0]        startBurst,
  input  logic [2:0]        startSize,
  input  logic [BEAT_W-1:0] startBeats,
  input  logic              grant,
  input  logic              ready,
  output logic [1:0]        busTrans,
  output logic [ADDR_W-1:0] busAddr,
  output logic [2:0]        busBurst,
  output logic [2:0]        busSize,
  output logic              busy,
  output logic              done
);

  seq_strobe_t strobe;
  trans_e      ctrlTrans;
  logic        breakNext;

  burst_seq_ctrl #(.MAX_BEATS(MAX_BEATS), .BEAT_W(BEAT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startBurst(startBurst),
    .startBeats(startBeats), .grant(grant), .ready(ready), .breakNext(breakNext),
    .strobe(strobe), .busTrans(ctrlTrans), .busy(busy), .done(done)
  );

  burst_seq_path #(.ADDR_W(ADDR_W), .MAX_BEATS(MAX_BEATS), .BEAT_W(BEAT_W), .KB_LG(KB_LG)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startAddr(startAddr),
    .startBurst(startBurst), .startSize(startSize), .startBeats(startBeats),
    .addrOut(busAddr), .burstOut(busBurst), .sizeOut(busSize), .breakNext(breakNext)
  );

  assign busTrans = ctrlTrans;

  assert_addr_hold_on_wait_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busTrans[1] && !ready) |=> ($stable(busAddr) && $stable(busBurst)));

  assert_fixed_incr_in_kb_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busTrans == 2'b11 && busBurst[0] && busBurst != BT_INCR) |->
      (busAddr[ADDR_W-1:KB_LG] == $past(busAddr[ADDR_W-1:KB_LG])));

endmodule

// File: tb/tb_burst_seq_master.sv
`timescale 1ns/1ps
module tb_burst_seq_master;

  localparam int AW = 16;
  localparam int MB = 20;
  localparam int BW = $clog2(MB + 1);

  logic          clk = 1'b0;
  logic          rstN, startReq, grant, ready;
  logic [AW-1:0] startAddr;
  logic [2:0]    startBurst, startSize;
  logic [BW-1:0] startBeats;
  logic [1:0]    busTrans;
  logic [AW-1:0] busAddr;
  logic [2:0]    busBurst, busSize;
  logic          busy, done;

  burst_seq_master #(.ADDR_W(AW), .MAX_BEATS(MB), .KB_LG(10)) dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startAddr(startAddr),
    .startBurst(startBurst), .startSize(startSize), .startBeats(startBeats),
    .grant(grant), .ready(ready), .busTrans(busTrans), .busAddr(busAddr),
    .busBurst(busBurst), .busSize(busSize), .busy(busy), .done(done)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0, stepNo = 0, doneCount = 0, doneStep = 0, lastAcceptStep = 0;
  int logCount = 0;
  logic [1:0]    logTrans [0:31];
  logic [AW-1:0] logAddr  [0:31];
  logic [2:0]    logBurst [0:31];
  logic          sampBusy, sampDone, prevActive, prevReady, finished = 1'b0;
  logic [1:0]    sampTrans, prevTrans;
  logic [AW-1:0] prevAddr;
  logic [2:0]    prevBurst;

  task automatic checkEq(input string tag, input string what, input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic clearLog();
    for (int i = 0; i < 32; i++) begin
      logTrans[i] = '0; logAddr[i] = '0; logBurst[i] = '0;
    end
    logCount = 0;
  endtask

  // one bus cycle: sample outputs, then drive inputs for the coming edge
  task automatic stepBus(input logic r, input logic g, input logic s);
    @(negedge clk);
    stepNo++;
    sampBusy  = busy;
    sampDone  = done;
    sampTrans = busTrans;
    if (done) begin doneCount++; doneStep = stepNo; end
    if (prevActive && !prevReady) begin
      checkEq("R4", "held trans", busTrans, prevTrans);
      checkEq("R4", "held addr", busAddr, prevAddr);
      checkEq("R4", "held burst", busBurst, prevBurst);
    end
    ready = r; grant = g; startReq = s;
    if (busTrans[1] && r) begin
      if (logCount < 32) begin
        logTrans[logCount] = busTrans;
        logAddr[logCount]  = busAddr;
        logBurst[logCount] = busBurst;
      end
      logCount++;
      lastAcceptStep = stepNo;
    end
    prevActive = busTrans[1]; prevReady = r;
    prevTrans = busTrans; prevAddr = busAddr; prevBurst = busBurst;
  endtask

  task automatic startOne(input logic [AW-1:0] a, input logic [2:0] b, input logic [2:0] sz,
                          input logic [BW-1:0] n);
    @(negedge clk);
    stepNo++;
    prevActive = 1'b0;
    startAddr = a; startBurst = b; startSize = sz; startBeats = n;
    startReq = 1'b1; ready = 1'b1;
  endtask

  task automatic runToEnd(input logic alt);
    for (int i = 0; i < 80; i++) begin
      stepBus(alt ? logic'(i % 2) : 1'b1, 1'b1, 1'b0);
      if (!sampBusy) break;
    end
  endtask

  task automatic expectBeat(input int idx, input logic [1:0] tr, input logic [AW-1:0] ad,
                            input logic [2:0] bu, input string tag);
    checkEq(tag, $sformatf("beat%0d trans", idx), logTrans[idx], tr);
    checkEq(tag, $sformatf("beat%0d addr", idx), logAddr[idx], ad);
    checkEq(tag, $sformatf("beat%0d burst", idx), logBurst[idx], bu);
  endtask

  task automatic testReset();
    @(negedge clk);
    checkEq("R1", "trans", busTrans, 2'b00);
    checkEq("R1", "busy", busy, 0);
    checkEq("R1", "done", done, 0);
    for (int i = 0; i < 2; i++) stepBus(1'b1, 1'b1, 1'b0);
  endtask

  task automatic testIncr4();
    int d0 = doneCount;
    clearLog();
    startOne(16'h0038, 3'b011, 3'd2, '0);
    runToEnd(1'b0);
    checkEq("R5", "incr4 beats", logCount, 4);
    expectBeat(0, 2'b10, 16'h0038, 3'b011, "R2");
    expectBeat(1, 2'b11, 16'h003C, 3'b011, "R3");
    expectBeat(2, 2'b11, 16'h0040, 3'b011, "R3");
    expectBeat(3, 2'b11, 16'h0044, 3'b011, "R3");
    checkEq("R10", "done pulses", doneCount - d0, 1);
    checkEq("R10", "done delay", doneStep - lastAcceptStep, 2);
    checkEq("R10", "busy with done", sampBusy, 0);
  endtask

  task automatic testWrap4Wait();
    int d0 = doneCount;
    clearLog();
    startOne(16'h0034, 3'b010, 3'd2, '0);
    runToEnd(1'b1);
    checkEq("R4", "wrap4 beats under waits", logCount, 4);
    expectBeat(0, 2'b10, 16'h0034, 3'b010, "R3");
    expectBeat(1, 2'b11, 16'h0038, 3'b010, "R3");
    expectBeat(2, 2'b11, 16'h003C, 3'b010, "R3");
    expectBeat(3, 2'b11, 16'h0030, 3'b010, "R3");
    checkEq("R10", "done pulses", doneCount - d0, 1);
  endtask

  task automatic testWrap8();
    logic [AW-1:0] exp [0:7] = '{16'h34, 16'h38, 16'h3C, 16'h20, 16'h24, 16'h28, 16'h2C, 16'h30};
    clearLog();
    startOne(16'h0034, 3'b100, 3'd2, '0);
    runToEnd(1'b0);
    checkEq("R5", "wrap8 beats", logCount, 8);
    for (int i = 0; i < 8; i++) expectBeat(i, (i == 0) ? 2'b10 : 2'b11, exp[i], 3'b100, "R3");
  endtask

  task automatic testIncr8Half();
    clearLog();
    startOne(16'h0034, 3'b101, 3'd1, '0);
    runToEnd(1'b0);
    checkEq("R5", "incr8 beats", logCount, 8);
    for (int i = 0; i < 8; i++)
      expectBeat(i, (i == 0) ? 2'b10 : 2'b11, AW'(16'h34 + 2 * i), 3'b101, "R3");
  endtask

  task automatic testOpenLength();
    clearLog();
    startOne(16'h005C, 3'b001, 3'd2, BW'(3));
    runToEnd(1'b0);
    checkEq("R5", "incr 3 beats", logCount, 3);
    expectBeat(0, 2'b10, 16'h005C, 3'b001, "R5");
    expectBeat(2, 2'b11, 16'h0064, 3'b001, "R5");
    clearLog();
    startOne(16'h0080, 3'b001, 3'd2, '0);
    runToEnd(1'b0);
    checkEq("R5", "incr count 0 gives 1", logCount, 1);
    clearLog();
    startOne(16'h0013, 3'b000, 3'd0, BW'(7));
    runToEnd(1'b0);
    checkEq("R5", "single beats", logCount, 1);
    expectBeat(0, 2'b10, 16'h0013, 3'b000, "R5");
  endtask

  task automatic testGrantLoss();
    int d0 = doneCount;
    clearLog();
    startOne(16'h0100, 3'b011, 3'd2, '0);
    stepBus(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      stepBus(1'b1, 1'b0, 1'b0);
      checkEq("R6", "idle without grant", sampTrans, 2'b00);
    end
    runToEnd(1'b0);
    checkEq("R7", "resumed beats", logCount, 4);
    expectBeat(0, 2'b10, 16'h0100, 3'b011, "R7");
    expectBeat(1, 2'b10, 16'h0104, 3'b001, "R7");
    expectBeat(2, 2'b11, 16'h0108, 3'b001, "R7");
    expectBeat(3, 2'b11, 16'h010C, 3'b001, "R7");
    checkEq("R10", "done after split", doneCount - d0, 1);
  endtask

  task automatic testWrapResume();
    clearLog();
    startOne(16'h0038, 3'b010, 3'd2, '0);
    stepBus(1'b1, 1'b0, 1'b0);
    stepBus(1'b1, 1'b0, 1'b0);
    runToEnd(1'b0);
    checkEq("R8", "wrap resume beats", logCount, 4);
    expectBeat(0, 2'b10, 16'h0038, 3'b010, "R8");
    expectBeat(1, 2'b10, 16'h003C, 3'b001, "R8");
    expectBeat(2, 2'b10, 16'h0030, 3'b001, "R8");
    expectBeat(3, 2'b11, 16'h0034, 3'b001, "R8");
  endtask

  task automatic testKb();
    clearLog();
    startOne(16'h03F8, 3'b011, 3'd2, '0);
    runToEnd(1'b0);
    checkEq("R9", "kb beats", logCount, 4);
    expectBeat(0, 2'b10, 16'h03F8, 3'b001, "R9");
    expectBeat(1, 2'b11, 16'h03FC, 3'b001, "R9");
    expectBeat(2, 2'b10, 16'h0400, 3'b001, "R9");
    expectBeat(3, 2'b11, 16'h0404, 3'b001, "R9");
    clearLog();
    startOne(16'h07FC, 3'b001, 3'd2, BW'(3));
    runToEnd(1'b0);
    expectBeat(0, 2'b10, 16'h07FC, 3'b001, "R9");
    expectBeat(1, 2'b10, 16'h0800, 3'b001, "R9");
    expectBeat(2, 2'b11, 16'h0804, 3'b001, "R9");
  endtask

  task automatic testStartIgnored();
    int d0 = doneCount;
    clearLog();
    startOne(16'h0200, 3'b011, 3'd2, '0);
    stepBus(1'b1, 1'b1, 1'b0);
    startAddr = 16'h0900; startBurst = 3'b000; startSize = 3'd0;
    stepBus(1'b1, 1'b1, 1'b1);
    runToEnd(1'b0);
    for (int i = 0; i < 3; i++) stepBus(1'b1, 1'b1, 1'b0);
    checkEq("R11", "beats with extra start", logCount, 4);
    expectBeat(2, 2'b11, 16'h0208, 3'b011, "R11");
    expectBeat(3, 2'b11, 16'h020C, 3'b011, "R11");
    checkEq("R11", "single done", doneCount - d0, 1);
    checkEq("R11", "busy after", sampBusy, 0);
  endtask

  task automatic testLateGrant();
    clearLog();
    stepBus(1'b1, 1'b0, 1'b0);
    stepBus(1'b1, 1'b0, 1'b0);
    startOne(16'h0048, 3'b010, 3'd2, '0);
    for (int i = 0; i < 3; i++) begin
      stepBus(1'b1, 1'b0, 1'b0);
      checkEq("R6", "idle before grant", sampTrans, 2'b00);
    end
    runToEnd(1'b0);
    checkEq("R12", "late grant beats", logCount, 4);
    expectBeat(0, 2'b10, 16'h0048, 3'b010, "R12");
    expectBeat(1, 2'b11, 16'h004C, 3'b010, "R12");
    expectBeat(2, 2'b11, 16'h0040, 3'b010, "R12");
    expectBeat(3, 2'b11, 16'h0044, 3'b010, "R12");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; startReq = 1'b0; grant = 1'b1; ready = 1'b1;
    startAddr = '0; startBurst = '0; startSize = '0; startBeats = '0;
    prevActive = 1'b0; prevReady = 1'b1; prevTrans = '0; prevAddr = '0; prevBurst = '0;
    sampBusy = 1'b0; sampDone = 1'b0; sampTrans = '0;
    clearLog();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testIncr4();
    testWrap4Wait();
    testWrap8();
    testIncr8Half();
    testOpenLength();
    testGrantLoss();
    testWrapResume();
    testKb();
    testStartIgnored();
    testLateGrant();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule